// File: doc/BRIEF.md
# Mixed-Page-Size Address Translation Buffer

This block is a small, fully associative translation buffer that turns a 32-bit virtual address into a physical address in the same cycle as the request. Each entry describes one page whose size is chosen per entry from four options (1 kB, 4 kB, 64 kB or 1 MB), so a single lookup compares each entry over a different span of upper address bits. The offset bits below the page boundary pass through untouched.

Each lookup also decides whether the access (read, write or fetch) is allowed for the caller's privilege level. It raises one of three fault codes: no matching entry, rights violation, or first store to a page still marked clean. Any faulting lookup records its virtual address in a readable fault-address register.

Software fills the buffer one entry at a time. A load writes the slot named by a replacement pointer, and the pointer then moves to the next slot. Software may overwrite the pointer at any time to steer where the next load lands.

Top module: `tlb_xlate`

## Requirements
- R1: An entry matches when its valid bit is set and its stored page number equals the virtual address over the span set by its 2-bit size code: code 0 compares bits [31:10], code 1 bits [31:12], code 2 bits [31:16], code 3 bits [31:20].
- R2: On a match the physical address takes the entry's frame over that same upper span, and all lower virtual bits are copied through unchanged.
- R3: With privilege asserted, the low two bits of the 3-bit rights code grant: 0 read only, 1 read and fetch, 2 read and write, 3 read, write and fetch; access encoding is 0 read, 1 write, 2 fetch.
- R4: Without privilege, rights codes 0 to 3 allow nothing, and codes 4 to 7 grant exactly what R3 gives for their low two bits.
- R5: A write that matches an entry with the rights it needs but a clear dirty bit reports fault code 3 instead of success.
- R6: Fault codes are 0 none, 1 no match, 2 rights violation, 3 clean-page store; no match outranks a rights violation, which outranks a clean-page store; the hit output is high exactly when some entry matched.
- R7: At each clock edge where a valid lookup reports a nonzero fault code, the fault-address register takes that lookup's virtual address; otherwise it holds.
- R8: A software load writes the slot the replacement pointer names, then the pointer advances by one, wrapping from 15 back to 0.
- R9: A pointer write stores the written value modulo 16 and wins over the advance when a load happens in the same cycle (the load still uses the old pointer).
- R10: When several valid entries match, the one in the lowest-numbered slot supplies the translation, rights, dirty and write-through bits.
- R11: On a match the write-through output reflects the matching entry's write-through bit; without a match it is 0.
- R12: Synchronous reset clears every valid bit, the pointer and the fault-address register; with request valid low the outputs show no hit, fault code 0, and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lkValid | input | 1 | Lookup request valid |
| lkVaddr | input | 32 | Virtual address to translate |
| lkAccess | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| lkPriv | input | 1 | High for privileged caller |
| rspHit | output | 1 | Some valid entry matched |
| rspPaddr | output | 32 | Translated physical address |
| rspExc | output | 2 | Fault code |
| rspWriteThru | output | 1 | Write-through hint of the matching entry |
| ldValid | input | 1 | Software entry load strobe |
| ldVpn | input | 22 | Page number, virtual bits [31:10] |
| ldPfn | input | 22 | Frame number, physical bits [31:10] |
| ldSize | input | 2 | Page size code |
| ldPerm | input | 3 | Rights code |
| ldDirty | input | 1 | Page already written |
| ldWriteThru | input | 1 | Write-through hint |
| ldEntValid | input | 1 | Valid bit of the loaded entry |
| ptrWrEn | input | 1 | Replacement pointer write strobe |
| ptrWrData | input | 6 | Value to write into the pointer |
| ptrOut | output | 6 | Current replacement pointer |
| faultAddr | output | 32 | Virtual address of the last faulting lookup |

## Verification
The bench goes after addresses one byte inside and one byte outside each page size. A design that compared the wrong span would either hit the neighbouring page or miss its own last byte, and one that masked the frame wrongly would leak page-number bits into the offset. It sweeps every rights code against both privilege levels, all three access kinds and both dirty values. Swapped rights bits, a missing privilege gate or a misordered fault priority would therefore show up as a wrong fault code. It also stacks overlapping entries of different sizes so that a reversed priority encoder returns the wrong frame. It drives the pointer through its wrap and through a same-cycle write and load, where a design favouring the advance would land one slot off.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int VA_W     = 32;
  localparam int PAGE_MIN = 10;
  localparam int TAG_W    = VA_W - PAGE_MIN;
  localparam int PTR_W    = 6;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'b00,
    EXC_MISS    = 2'b01,
    EXC_PROT    = 2'b10,
    EXC_CLEANWR = 2'b11
  } exc_e;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] vpn;
    logic [TAG_W-1:0] pfn;
    logic [1:0]       size;
    logic [2:0]       perm;
    logic             dirty;
    logic             wthru;
  } entry_t;

  typedef struct packed {
    logic             loadEntry;
    logic [PTR_W-1:0] loadSlot;
    logic             captureFault;
  } strobe_t;

  // Bits of the page-number field that take part in the compare.
  function automatic logic [TAG_W-1:0] tagMask(input logic [1:0] size);
    logic [TAG_W-1:0] m;
    case (size)
      2'b00:   m = {TAG_W{1'b1}};
      2'b01:   m = {{(TAG_W-2){1'b1}}, 2'b00};
      2'b10:   m = {{(TAG_W-6){1'b1}}, 6'b00_0000};
      default: m = {{(TAG_W-10){1'b1}}, 10'b00_0000_0000};
    endcase
    return m;
  endfunction

  function automatic logic accessOk(input logic [2:0] perm, input logic priv,
                                    input acc_e acc);
    logic modeOk;
    logic rightOk;
    modeOk = priv | perm[2];
    case (acc)
      ACC_WRITE: rightOk = perm[1];
      ACC_EXEC:  rightOk = perm[0];
      default:   rightOk = 1'b1;
    endcase
    return modeOk & rightOk;
  endfunction

endpackage

// File: rtl/tlb_slot_match.sv
module tlb_slot_match
  import tlb_pkg::*;
(
  input  entry_t           ent,
  input  logic [TAG_W-1:0] vaTag,
  output logic             hit,
  output logic [TAG_W-1:0] frame
);

  logic [TAG_W-1:0] cmpMask;

  always_comb begin
    cmpMask = tagMask(ent.size);
    hit     = ent.valid && (((ent.vpn ^ vaTag) & cmpMask) == '0);
    frame   = (ent.pfn & cmpMask) | (vaTag & ~cmpMask);
  end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ldValid,
  input  logic             ptrWrEn,
  input  logic [PTR_W-1:0] ptrWrData,
  input  logic             lkValid,
  input  logic [1:0]       lkExc,
  output strobe_t          strb,
  output logic [PTR_W-1:0] ptrOut
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(ENTRIES - 1);
  localparam logic [PTR_W-1:0] SLOT_CNT  = PTR_W'(ENTRIES);

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptrStep;

  assign ptrStep = (ptr == LAST_SLOT) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ptrWrEn) begin
      ptr <= ptrWrData % SLOT_CNT;
    end else if (ldValid) begin
      ptr <= ptrStep;
    end
  end

  always_comb begin
    strb.loadEntry    = ldValid;
    strb.loadSlot     = ptr;
    strb.captureFault = lkValid && (exc_e'(lkExc) != EXC_NONE);
  end

  assign ptrOut = ptr;

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic [TAG_W-1:0] ldVpn,
  input  logic [TAG_W-1:0] ldPfn,
  input  logic [1:0]       ldSize,
  input  logic [2:0]       ldPerm,
  input  logic             ldDirty,
  input  logic             ldWriteThru,
  input  logic             ldEntValid,
  input  logic             lkValid,
  input  logic [VA_W-1:0]  lkVaddr,
  input  logic [1:0]       lkAccess,
  input  logic             lkPriv,
  output logic             rspHit,
  output logic [VA_W-1:0]  rspPaddr,
  output logic [1:0]       rspExc,
  output logic             rspWriteThru,
  output logic [VA_W-1:0]  faultAddr
);

  entry_t           entTab    [ENTRIES];
  entry_t           newEnt;
  logic [ENTRIES-1:0] slotHit;
  logic [TAG_W-1:0] slotFrame [ENTRIES];
  logic [TAG_W-1:0] vaTag;

  logic             anyHit;
  entry_t           selEnt;
  logic [TAG_W-1:0] selFrame;

  assign vaTag = lkVaddr[VA_W-1:PAGE_MIN];

  always_comb begin
    newEnt.valid = ldEntValid;
    newEnt.vpn   = ldVpn;
    newEnt.pfn   = ldPfn;
    newEnt.size  = ldSize;
    newEnt.perm  = ldPerm;
    newEnt.dirty = ldDirty;
    newEnt.wthru = ldWriteThru;
  end

  // Entry storage: only the valid bits are cleared by reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) entTab[i].valid <= 1'b0;
    end else if (strb.loadEntry) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strb.loadSlot == PTR_W'(i)) entTab[i] <= newEnt;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_slot_match u_match (
      .ent   (entTab[g]),
      .vaTag (vaTag),
      .hit   (slotHit[g]),
      .frame (slotFrame[g])
    );
  end

  // Lowest-numbered matching slot wins: scan downward, last writer is slot 0 side.
  always_comb begin
    anyHit   = 1'b0;
    selEnt   = '0;
    selFrame = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (slotHit[i]) begin
        anyHit   = 1'b1;
        selEnt   = entTab[i];
        selFrame = slotFrame[i];
      end
    end
  end

  always_comb begin
    rspHit       = 1'b0;
    rspPaddr     = '0;
    rspExc       = EXC_NONE;
    rspWriteThru = 1'b0;
    if (lkValid) begin
      if (!anyHit) begin
        rspExc = EXC_MISS;
      end else begin
        rspHit       = 1'b1;
        rspPaddr     = {selFrame, lkVaddr[PAGE_MIN-1:0]};
        rspWriteThru = selEnt.wthru;
        if (!accessOk(selEnt.perm, lkPriv, acc_e'(lkAccess))) begin
          rspExc = EXC_PROT;
        end else if ((acc_e'(lkAccess) == ACC_WRITE) && !selEnt.dirty) begin
          rspExc = EXC_CLEANWR;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      faultAddr <= '0;
    end else if (strb.captureFault) begin
      faultAddr <= lkVaddr;
    end
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lkValid,
  input  logic [31:0] lkVaddr,
  input  logic [1:0]  lkAccess,
  input  logic        lkPriv,
  output logic        rspHit,
  output logic [31:0] rspPaddr,
  output logic [1:0]  rspExc,
  output logic        rspWriteThru,
  input  logic        ldValid,
  input  logic [21:0] ldVpn,
  input  logic [21:0] ldPfn,
  input  logic [1:0]  ldSize,
  input  logic [2:0]  ldPerm,
  input  logic        ldDirty,
  input  logic        ldWriteThru,
  input  logic        ldEntValid,
  input  logic        ptrWrEn,
  input  logic [5:0]  ptrWrData,
  output logic [5:0]  ptrOut,
  output logic [31:0] faultAddr
);

  strobe_t strb;

  tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ldValid   (ldValid),
    .ptrWrEn   (ptrWrEn),
    .ptrWrData (ptrWrData),
    .lkValid   (lkValid),
    .lkExc     (rspExc),
    .strb      (strb),
    .ptrOut    (ptrOut)
  );

  tlb_datapath #(.ENTRIES(ENTRIES)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .ldVpn        (ldVpn),
    .ldPfn        (ldPfn),
    .ldSize       (ldSize),
    .ldPerm       (ldPerm),
    .ldDirty      (ldDirty),
    .ldWriteThru  (ldWriteThru),
    .ldEntValid   (ldEntValid),
    .lkValid      (lkValid),
    .lkVaddr      (lkVaddr),
    .lkAccess     (lkAccess),
    .lkPriv       (lkPriv),
    .rspHit       (rspHit),
    .rspPaddr     (rspPaddr),
    .rspExc       (rspExc),
    .rspWriteThru (rspWriteThru),
    .faultAddr    (faultAddr)
  );

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int ENTRIES = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        lkValid,
  input logic [31:0] lkVaddr,
  input logic [1:0]  lkAccess,
  input logic        rspHit,
  input logic [31:0] rspPaddr,
  input logic [1:0]  rspExc,
  input logic        ldValid,
  input logic        ptrWrEn,
  input logic [5:0]  ptrWrData,
  input logic [5:0]  ptrOut,
  input logic [31:0] faultAddr
);

  localparam logic [5:0] LAST_SLOT = 6'(ENTRIES - 1);
  localparam logic [5:0] SLOT_CNT  = 6'(ENTRIES);

  p_hit_vs_miss_r6: assert property (@(posedge clk) disable iff (rst)
    lkValid |-> (rspHit == (rspExc != 2'b01)));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !lkValid |-> (!rspHit && rspExc == 2'b00));

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (lkValid && rspHit) |-> (rspPaddr[9:0] == lkVaddr[9:0]));

  p_cleanwr_store_r5: assert property (@(posedge clk) disable iff (rst)
    (lkValid && rspExc == 2'b11) |-> (lkAccess == 2'b01));

  p_fault_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (lkValid && rspExc != 2'b00) |=> (faultAddr == $past(lkVaddr)));

  p_fault_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(lkValid && rspExc != 2'b00) |=> $stable(faultAddr));

  p_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (ldValid && !ptrWrEn) |=>
      (ptrOut == (($past(ptrOut) == LAST_SLOT) ? 6'd0 : $past(ptrOut) + 6'd1)));

  p_ptr_write_r9: assert property (@(posedge clk) disable iff (rst)
    ptrWrEn |=> (ptrOut == ($past(ptrWrData) % SLOT_CNT)));

  p_reset_clear_r12: assert property (@(posedge clk)
    rst |=> (ptrOut == 6'd0 && faultAddr == 32'd0));

endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lkValid   (lkValid),
  .lkVaddr   (lkVaddr),
  .lkAccess  (lkAccess),
  .rspHit    (rspHit),
  .rspPaddr  (rspPaddr),
  .rspExc    (rspExc),
  .ldValid   (ldValid),
  .ptrWrEn   (ptrWrEn),
  .ptrWrData (ptrWrData),
  .ptrOut    (ptrOut),
  .faultAddr (faultAddr)
);

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lkValid = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic [1:0]  lkAccess = '0;
  logic        lkPriv = 1'b0;
  logic        rspHit;
  logic [31:0] rspPaddr;
  logic [1:0]  rspExc;
  logic        rspWriteThru;
  logic        ldValid = 1'b0;
  logic [21:0] ldVpn = '0;
  logic [21:0] ldPfn = '0;
  logic [1:0]  ldSize = '0;
  logic [2:0]  ldPerm = '0;
  logic        ldDirty = 1'b0;
  logic        ldWriteThru = 1'b0;
  logic        ldEntValid = 1'b0;
  logic        ptrWrEn = 1'b0;
  logic [5:0]  ptrWrData = '0;
  logic [5:0]  ptrOut;
  logic [31:0] faultAddr;

  always #5 clk = ~clk;

  tlb_xlate #(.ENTRIES(N)) u0 (.*);

  // Bench model of software-visible state
  logic        mValid [N];
  logic [21:0] mVpn   [N];
  logic [21:0] mPfn   [N];
  logic [1:0]  mSize  [N];
  logic [2:0]  mPerm  [N];
  logic        mDirty [N];
  logic        mWt    [N];
  int          mPtr;
  logic [31:0] mFault;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  task automatic expect32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int shiftOf(logic [1:0] s);
    case (s)
      2'd0: return 10;
      2'd1: return 12;
      2'd2: return 16;
      default: return 20;
    endcase
  endfunction

  function automatic void refLook(input logic [31:0] va, input logic [1:0] acc,
                                  input logic pr, output logic h, output logic [1:0] e,
                                  output logic [31:0] pa, output logic w);
    int sh;
    logic [31:0] vb;
    logic [31:0] fb;
    logic modeOk;
    logic rightOk;
    h = 0; e = 2'd1; pa = '0; w = 0;
    for (int i = 0; i < N; i++) begin
      if (h || !mValid[i]) continue;
      sh = shiftOf(mSize[i]);
      vb = {mVpn[i], 10'b0};
      fb = {mPfn[i], 10'b0};
      if ((va >> sh) == (vb >> sh)) begin
        h  = 1;
        pa = ((fb >> sh) << sh) | (va & ((32'd1 << sh) - 32'd1));
        w  = mWt[i];
        modeOk = pr || (mPerm[i] >= 3'd4);
        case (acc)
          2'd1:    rightOk = (mPerm[i][1:0] >= 2'd2);
          2'd2:    rightOk = (mPerm[i][1:0] == 2'd1) || (mPerm[i][1:0] == 2'd3);
          default: rightOk = 1'b1;
        endcase
        if (!(modeOk && rightOk)) e = 2'd2;
        else if (acc == 2'd1 && !mDirty[i]) e = 2'd3;
        else e = 2'd0;
      end
    end
  endfunction

  task automatic clearIns();
    lkValid = 0; ldValid = 0; ptrWrEn = 0;
  endtask

  task automatic look(logic [31:0] va, logic [1:0] acc, logic pr, string tag);
    logic h; logic [1:0] e; logic [31:0] pa; logic w;
    @(negedge clk);
    clearIns();
    lkValid = 1; lkVaddr = va; lkAccess = acc; lkPriv = pr;
    #1;
    refLook(va, acc, pr, h, e, pa, w);
    expect32(tag, "hit", {31'b0, rspHit}, {31'b0, h});
    expect32(tag, "exc", {30'b0, rspExc}, {30'b0, e});
    expect32(tag, "paddr", rspPaddr, pa);
    expect32({tag, " R11"}, "writethru", {31'b0, rspWriteThru}, {31'b0, w});
    @(posedge clk);
    if (e != 2'd0) mFault = va;
  endtask

  task automatic idleLook(logic [31:0] va);
    @(negedge clk);
    clearIns();
    lkVaddr = va; lkAccess = 2'd1; lkPriv = 0;
    #1;
    expect32("R12 idle", "hit", {31'b0, rspHit}, 32'd0);
    expect32("R12 idle", "exc", {30'b0, rspExc}, 32'd0);
    expect32("R12 idle", "paddr", rspPaddr, 32'd0);
    @(posedge clk);
  endtask

  task automatic loadEnt(logic [21:0] vpn, logic [21:0] pfn, logic [1:0] sz,
                         logic [2:0] perm, logic dty, logic wt, logic vld,
                         logic setP = 0, logic [5:0] pData = 0);
    @(negedge clk);
    clearIns();
    ldValid = 1; ldVpn = vpn; ldPfn = pfn; ldSize = sz; ldPerm = perm;
    ldDirty = dty; ldWriteThru = wt; ldEntValid = vld;
    ptrWrEn = setP; ptrWrData = pData;
    @(posedge clk);
    mValid[mPtr] = vld; mVpn[mPtr] = vpn; mPfn[mPtr] = pfn; mSize[mPtr] = sz;
    mPerm[mPtr] = perm; mDirty[mPtr] = dty; mWt[mPtr] = wt;
    mPtr = setP ? (int'(pData) % N) : ((mPtr + 1) % N);
  endtask

  task automatic setPtr(logic [5:0] d);
    @(negedge clk);
    clearIns();
    ptrWrEn = 1; ptrWrData = d;
    @(posedge clk);
    mPtr = int'(d) % N;
  endtask

  task automatic checkRegs(string tag);
    @(negedge clk);
    clearIns();
    #1;
    expect32(tag, "ptr", {26'b0, ptrOut}, 32'(mPtr));
    expect32(tag, "faultAddr", faultAddr, mFault);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog R12: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] base;
    logic [31:0] psz;
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0; mVpn[i] = '0; mPfn[i] = '0; mSize[i] = '0;
      mPerm[i] = '0; mDirty[i] = 0; mWt[i] = 0;
    end
    mPtr = 0; mFault = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // Reset state, empty buffer, fault register
    checkRegs("R12 reset");
    idleLook(32'h1234_5678);
    look(32'h1234_5678, 2'd0, 1'b1, "R6 R12 empty miss");
    checkRegs("R7 miss capture");

    // Pointer behaviour
    setPtr(6'h25);
    checkRegs("R9 write mod");
    loadEnt(22'h0, 22'h0, 2'd0, 3'd0, 0, 0, 0);
    checkRegs("R8 step");
    loadEnt(22'h0, 22'h0, 2'd0, 3'd0, 0, 0, 0, 1'b1, 6'h0E);
    checkRegs("R9 write beats step");
    loadEnt(22'h0, 22'h0, 2'd0, 3'd0, 0, 0, 0);
    loadEnt(22'h0, 22'h0, 2'd0, 3'd0, 0, 0, 0);
    checkRegs("R8 wrap");
    setPtr(6'd0);
    for (int i = 0; i < N; i++) loadEnt(22'h0, 22'h0, 2'd0, 3'd0, 0, 0, 0);
    checkRegs("R8 full cycle");

    // Page sizes: spans and pass-through bits
    for (int s = 0; s < 4; s++) begin
      base = 32'h1000_0000 * (s + 1);
      loadEnt(22'(base >> 10) | ((s == 0) ? 22'h0 : 22'h1), {12'hABC, 10'h3FF},
              2'(s), 3'd7, 1'b1, s[0], 1'b1);
    end
    for (int s = 0; s < 4; s++) begin
      base = 32'h1000_0000 * (s + 1);
      psz  = 32'd1 << shiftOf(2'(s));
      look(base, 2'd0, 1'b0, "R1 R2 first byte");
      look(base + psz - 1, 2'd1, 1'b1, "R1 R2 last byte");
      look(base + (psz >> 1) + 32'h5, 2'd2, 1'b0, "R1 R2 middle");
      look(base + psz, 2'd0, 1'b1, "R1 beyond page");
      look(base - 1, 2'd0, 1'b1, "R1 below page");
    end

    // Rights, privilege and dirty sweep on slot 8
    for (int p = 0; p < 8; p++) begin
      for (int d = 0; d < 2; d++) begin
        setPtr(6'd8);
        loadEnt(22'(32'h5000_0000 >> 10), 22'h15_5AA, 2'd1, 3'(p), d[0], ~d[0], 1'b1);
        for (int pr = 0; pr < 2; pr++) begin
          for (int a = 0; a < 3; a++) begin
            look(32'h5000_0ABC, 2'(a), pr[0], "R3 R4 R5 R6 rights");
          end
        end
      end
    end

    // Overlapping entries: lowest slot wins
    setPtr(6'd10);
    loadEnt(22'(32'h6000_0000 >> 10), 22'h01_1111, 2'd0, 3'd7, 1, 1, 1);
    setPtr(6'd12);
    loadEnt(22'(32'h6000_0000 >> 10), 22'h02_2222, 2'd0, 3'd4, 0, 0, 1);
    look(32'h6000_0123, 2'd1, 1'b0, "R10 same page");
    setPtr(6'd11);
    loadEnt(22'(32'h7000_0000 >> 10), 22'h30_0000, 2'd3, 3'd7, 1, 0, 1);
    loadEnt(22'(32'h7004_0000 >> 10), 22'h0F_0F0F, 2'd0, 3'd0, 0, 1, 1);
    look(32'h7004_0010, 2'd1, 1'b0, "R10 large page first");
    setPtr(6'd9);
    loadEnt(22'(32'h7008_0000 >> 10), 22'h0A_0A0A, 2'd0, 3'd3, 0, 1, 1);
    look(32'h7008_0020, 2'd0, 1'b1, "R10 small page first");
    look(32'h7008_0020, 2'd0, 1'b0, "R10 R4 small page rights");

    // Fault register capture and hold
    look(32'h5000_0ABC, 2'd0, 1'b1, "R7 clean lookup");
    checkRegs("R7 hold on success");
    look(32'hDEAD_BEEF, 2'd2, 1'b1, "R7 miss");
    checkRegs("R7 capture");
    idleLook(32'h1111_1111);
    checkRegs("R7 hold when idle");
    look(32'h6000_0200, 2'd1, 1'b1, "R7 R10 ok store");
    checkRegs("R7 hold after store");

    done = 1;
    summary();
  end

endmodule